// File: doc/BRIEF.md
# DMA Flow-Control Handshake Unit

This unit sits between a DMA channel's sequencer and the hardware request lines of the peripherals that the channel serves. It turns the channel's 3-bit transfer-type code into three facts: whether the source and the destination are memory or peripheral, and who decides when a block ends (the DMA engine by counting, the source peripheral, or the destination peripheral). For each side it then decides when a transaction may start and how many beats it carries, and it acknowledges every peripheral request it services.

A memory endpoint never waits: whenever the sequencer signals readiness on that side, a transaction of the programmed burst size goes out. A peripheral endpoint starts a transaction only on a request. If that peripheral owns the flow, its request type picks a single beat or a full burst, and its last signal ends the block. Otherwise the programmed burst size applies and the block length comes from the channel's own count. The beat counter and the memory bus are outside this unit.

Top module: `dfh_flow_unit`

## Requirements
- R1: Source is memory for transfer codes 000, 001 and 110, and a peripheral for all other codes. Destination is memory for codes 000, 010 and 100, and a peripheral for all other codes.
- R2: `flow_owner` reads 0 (DMA) for codes 000 to 011, 1 (source peripheral) for 100 and 101, and 2 (destination peripheral) for 110 and 111. `count_ends_block` is high exactly when the owner is the DMA.
- R3: Burst-size codes 0, 1, 2 and 3 give 1, 4, 8 and 16 beats. A code of 4 or above on either side raises `cfg_err`, and no transaction then starts on either side.
- R4: A memory side with `chan_en` high and its ready high starts a transaction one cycle after ready is sampled, with the programmed beat count, whatever its request inputs show, and never acknowledges.
- R5: A peripheral side that does not own the flow serves a single or a burst request alike with the programmed beat count.
- R6: A peripheral side that owns the flow starts one beat on a single request alone and the programmed burst on a burst request; a burst request wins when both are high.
- R7: Each serviced peripheral request gives an acknowledge that lasts one cycle and coincides with the start pulse. The burst flag is high exactly when the beat count exceeds one.
- R8: After servicing a request, a peripheral side starts nothing more until both of its request inputs have been low at a clock edge.
- R9: The block-done pulse of a side comes with the start pulse when that side owns the flow and its last input was high when the request was accepted. A last signal from a side that does not own the flow is ignored.
- R10: No transaction starts while `chan_en` or the side's ready is low, and a side never starts transactions in two consecutive cycles.
- R11: After reset all start, acknowledge, burst, beat-count and block-done outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| chan_en | input | 1 | Channel enabled |
| xfer_type | input | 3 | Transfer direction and flow-owner code |
| src_msize | input | 3 | Source burst-size code |
| dst_msize | input | 3 | Destination burst-size code |
| src_rdy | input | 1 | Sequencer ready for a source transaction |
| src_single | input | 1 | Source peripheral single request |
| src_burst_req | input | 1 | Source peripheral burst request |
| src_last | input | 1 | Source peripheral last-transaction flag |
| dst_rdy | input | 1 | Sequencer ready for a destination transaction |
| dst_single | input | 1 | Destination peripheral single request |
| dst_burst_req | input | 1 | Destination peripheral burst request |
| dst_last | input | 1 | Destination peripheral last-transaction flag |
| src_ack | output | 1 | Acknowledge to source peripheral |
| src_go | output | 1 | Start a source transaction |
| src_go_burst | output | 1 | Source transaction is a burst |
| src_go_beats | output | 5 | Beats in the source transaction |
| src_blk_done | output | 1 | Source peripheral ended the block |
| dst_ack | output | 1 | Acknowledge to destination peripheral |
| dst_go | output | 1 | Start a destination transaction |
| dst_go_burst | output | 1 | Destination transaction is a burst |
| dst_go_beats | output | 5 | Beats in the destination transaction |
| dst_blk_done | output | 1 | Destination peripheral ended the block |
| flow_owner | output | 2 | 0 DMA, 1 source, 2 destination |
| count_ends_block | output | 1 | Block length comes from the channel count |
| src_is_periph | output | 1 | Source is a peripheral |
| dst_is_periph | output | 1 | Destination is a peripheral |
| cfg_err | output | 1 | Unsupported burst-size code |

## Verification
The assertions watch, on every cycle, the shape of the handshake: acknowledges that last one cycle and come only with a start, no back-to-back starts, silence while a side waits for its request to drop, legal beat counts, no peripheral block end under count mode, and no start after a configuration error. What only the bench scenarios show is the mapping itself: the memory/peripheral decode and owner of all eight codes, the beat count for each request type under each owner, and the last signal being taken or ignored. The bench sweeps every transfer code, burst code and request combination on both sides.

// File: rtl/dfh_pkg.sv
package dfh_pkg;
  localparam int MAX_BURST_LOG = 4;
  localparam int BEAT_W = MAX_BURST_LOG + 1;
  localparam int TT_W = 3;
  localparam int MSZ_W = 3;
  localparam int LEGAL_MSZ = 4;

  typedef enum logic [1:0] {
    FC_DMA = 2'd0,
    FC_SRC = 2'd1,
    FC_DST = 2'd2
  } fc_owner_e;

  typedef enum logic {
    SD_IDLE = 1'b0,
    SD_DROP = 1'b1
  } side_state_e;

  function automatic logic src_on_periph(input logic [TT_W-1:0] tt);
    case (tt)
      3'b000, 3'b001, 3'b110: return 1'b0;
      default: return 1'b1;
    endcase
  endfunction

  function automatic logic dst_on_periph(input logic [TT_W-1:0] tt);
    case (tt)
      3'b000, 3'b010, 3'b100: return 1'b0;
      default: return 1'b1;
    endcase
  endfunction

  function automatic fc_owner_e owner_of(input logic [TT_W-1:0] tt);
    if (!tt[2]) return FC_DMA;
    return tt[1] ? FC_DST : FC_SRC;
  endfunction

  function automatic logic msize_legal(input logic [MSZ_W-1:0] code);
    return 32'(code) < LEGAL_MSZ;
  endfunction

  function automatic logic [BEAT_W-1:0] msize_to_beats(input logic [MSZ_W-1:0] code);
    if (code == '0) return BEAT_W'(1);
    return BEAT_W'(1) << (code + MSZ_W'(1));
  endfunction
endpackage

// File: rtl/dfh_decode.sv
module dfh_decode
  import dfh_pkg::*;
(
  input  logic [TT_W-1:0]   tt,
  input  logic [MSZ_W-1:0]  src_msz,
  input  logic [MSZ_W-1:0]  dst_msz,
  output logic              src_periph,
  output logic              dst_periph,
  output fc_owner_e         owner,
  output logic              count_mode,
  output logic              cfg_err,
  output logic [BEAT_W-1:0] src_beats,
  output logic [BEAT_W-1:0] dst_beats
);
  always_comb begin
    src_periph = src_on_periph(tt);
    dst_periph = dst_on_periph(tt);
    owner      = owner_of(tt);
    count_mode = (owner == FC_DMA);
    cfg_err    = !msize_legal(src_msz) || !msize_legal(dst_msz);
    src_beats  = msize_to_beats(src_msz);
    dst_beats  = msize_to_beats(dst_msz);
  end
endmodule

// File: rtl/dfh_side.sv
module dfh_side
  import dfh_pkg::*;
#(
  parameter bit IS_DST = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              is_periph,
  input  fc_owner_e         owner,
  input  logic [BEAT_W-1:0] cfg_beats,
  input  logic              rdy,
  input  logic              sreq,
  input  logic              breq,
  input  logic              last,
  output logic              ack,
  output logic              go,
  output logic              go_burst,
  output logic [BEAT_W-1:0] go_beats,
  output logic              blk_done
);
  localparam fc_owner_e MY_ROLE = IS_DST ? FC_DST : FC_SRC;

  side_state_e       st_q;
  logic              req_any;
  logic              is_owner;
  logic              accept;
  logic [BEAT_W-1:0] nxt_beats;

  always_comb begin
    req_any   = sreq | breq;
    is_owner  = is_periph && (owner == MY_ROLE);
    accept    = en && rdy && !go &&
                (!is_periph || (st_q == SD_IDLE && req_any));
    nxt_beats = (is_owner && !breq) ? BEAT_W'(1) : cfg_beats;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= SD_IDLE;
      go       <= 1'b0;
      ack      <= 1'b0;
      blk_done <= 1'b0;
      go_burst <= 1'b0;
      go_beats <= '0;
    end else begin
      go       <= accept;
      ack      <= accept && is_periph;
      blk_done <= accept && is_owner && last;
      if (accept) begin
        go_beats <= nxt_beats;
        go_burst <= nxt_beats > BEAT_W'(1);
      end
      if (accept && is_periph) st_q <= SD_DROP;
      else if (st_q == SD_DROP && !req_any) st_q <= SD_IDLE;
    end
  end

  a_r7_ack_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !ack);
  a_r7_ack_with_go: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> go);
  a_r4_mem_no_ack: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> $past(is_periph));
  a_r9_done_with_ack: assert property (@(posedge clk) disable iff (!rst_n)
    blk_done |-> (ack && go));
  a_r10_no_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> !go);
  a_r8_wait_for_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SD_DROP) |=> !go);
  a_r3_legal_beats: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> (go_beats == 5'd1 || go_beats == 5'd4 || go_beats == 5'd8 || go_beats == 5'd16));
endmodule

// File: rtl/dfh_flow_unit.sv
module dfh_flow_unit
  import dfh_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chan_en,
  input  logic [TT_W-1:0]   xfer_type,
  input  logic [MSZ_W-1:0]  src_msize,
  input  logic [MSZ_W-1:0]  dst_msize,
  input  logic              src_rdy,
  input  logic              src_single,
  input  logic              src_burst_req,
  input  logic              src_last,
  input  logic              dst_rdy,
  input  logic              dst_single,
  input  logic              dst_burst_req,
  input  logic              dst_last,
  output logic              src_ack,
  output logic              src_go,
  output logic              src_go_burst,
  output logic [BEAT_W-1:0] src_go_beats,
  output logic              src_blk_done,
  output logic              dst_ack,
  output logic              dst_go,
  output logic              dst_go_burst,
  output logic [BEAT_W-1:0] dst_go_beats,
  output logic              dst_blk_done,
  output logic [1:0]        flow_owner,
  output logic              count_ends_block,
  output logic              src_is_periph,
  output logic              dst_is_periph,
  output logic              cfg_err
);
  localparam int NSIDE = 2;

  fc_owner_e         owner;
  logic [BEAT_W-1:0] src_cfg_beats;
  logic [BEAT_W-1:0] dst_cfg_beats;
  logic              side_en;

  logic [NSIDE-1:0]  periph_v, rdy_v, sreq_v, breq_v, last_v;
  logic [NSIDE-1:0]  ack_v, go_v, burst_v, done_v;
  logic [BEAT_W-1:0] cfgb_v  [NSIDE];
  logic [BEAT_W-1:0] beats_v [NSIDE];

  dfh_decode u_decode (
    .tt         (xfer_type),
    .src_msz    (src_msize),
    .dst_msz    (dst_msize),
    .src_periph (src_is_periph),
    .dst_periph (dst_is_periph),
    .owner      (owner),
    .count_mode (count_ends_block),
    .cfg_err    (cfg_err),
    .src_beats  (src_cfg_beats),
    .dst_beats  (dst_cfg_beats)
  );

  always_comb begin
    side_en    = chan_en && !cfg_err;
    flow_owner = owner;
    periph_v   = {dst_is_periph, src_is_periph};
    rdy_v      = {dst_rdy, src_rdy};
    sreq_v     = {dst_single, src_single};
    breq_v     = {dst_burst_req, src_burst_req};
    last_v     = {dst_last, src_last};
    cfgb_v[0]  = src_cfg_beats;
    cfgb_v[1]  = dst_cfg_beats;
  end

  for (genvar s = 0; s < NSIDE; s++) begin : g_side
    dfh_side #(.IS_DST(s == 1)) u_side (
      .clk       (clk),
      .rst_n     (rst_n),
      .en        (side_en),
      .is_periph (periph_v[s]),
      .owner     (owner),
      .cfg_beats (cfgb_v[s]),
      .rdy       (rdy_v[s]),
      .sreq      (sreq_v[s]),
      .breq      (breq_v[s]),
      .last      (last_v[s]),
      .ack       (ack_v[s]),
      .go        (go_v[s]),
      .go_burst  (burst_v[s]),
      .go_beats  (beats_v[s]),
      .blk_done  (done_v[s])
    );
  end

  always_comb begin
    src_ack      = ack_v[0];
    src_go       = go_v[0];
    src_go_burst = burst_v[0];
    src_go_beats = beats_v[0];
    src_blk_done = done_v[0];
    dst_ack      = ack_v[1];
    dst_go       = go_v[1];
    dst_go_burst = burst_v[1];
    dst_go_beats = beats_v[1];
    dst_blk_done = done_v[1];
  end

  a_r2_no_periph_end_in_count_mode: assert property (@(posedge clk) disable iff (!rst_n)
    (src_blk_done || dst_blk_done) |-> !$past(count_ends_block));
  a_r3_err_blocks_start: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |=> (!src_go && !dst_go));
  a_r10_disabled_no_start: assert property (@(posedge clk) disable iff (!rst_n)
    !chan_en |=> (!src_go && !dst_go));
endmodule

// File: tb/test_dfh_flow_unit.sv
`timescale 1ns/100ps
module test_dfh_flow_unit;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic chan_en = 1'b0;
  logic [2:0] xfer_type = '0, src_msize = '0, dst_msize = '0;
  logic src_rdy = 0, src_single = 0, src_burst_req = 0, src_last = 0;
  logic dst_rdy = 0, dst_single = 0, dst_burst_req = 0, dst_last = 0;
  logic src_ack, src_go, src_go_burst, src_blk_done;
  logic dst_ack, dst_go, dst_go_burst, dst_blk_done;
  logic [4:0] src_go_beats, dst_go_beats;
  logic [1:0] flow_owner;
  logic count_ends_block, src_is_periph, dst_is_periph, cfg_err;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  dfh_flow_unit i_dfh_flow_unit (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  endtask

  function automatic bit m_periph(input int side, input int tt);
    if (side == 0) return !(tt == 0 || tt == 1 || tt == 6);
    return !(tt == 0 || tt == 2 || tt == 4);
  endfunction

  function automatic int m_owner(input int tt);
    if (tt < 4) return 0;
    if (tt < 6) return 1;
    return 2;
  endfunction

  function automatic int m_beats(input int code);
    case (code)
      0: return 1;
      1: return 4;
      2: return 8;
      default: return 16;
    endcase
  endfunction

  task automatic set_side(input int side, input logic rdy, input logic sr, input logic br, input logic ls);
    if (side == 0) begin
      src_rdy = rdy; src_single = sr; src_burst_req = br; src_last = ls;
    end else begin
      dst_rdy = rdy; dst_single = sr; dst_burst_req = br; dst_last = ls;
    end
  endtask

  task automatic idle_all();
    set_side(0, 0, 0, 0, 0);
    set_side(1, 0, 0, 0, 0);
  endtask

  // One serviced (or refused) transaction on a side; expectations from the requirements.
  task automatic run_txn(input int side, input int tt, input int msz,
                         input logic sr, input logic br, input logic ls, input logic en);
    logic [31:0] got, exp;
    int eb, ego, eack, edone;
    @(negedge clk);
    chan_en = en; xfer_type = 3'(tt); src_msize = 3'(msz); dst_msize = 3'(msz);
    set_side(side, 1, sr, br, ls);
    @(negedge clk);
    eb = 0; ego = 0; eack = 0; edone = 0;
    if (en && msz < 4) begin
      if (!m_periph(side, tt)) begin
        ego = 1; eb = m_beats(msz);
      end else if (sr || br) begin
        ego = 1; eack = 1;
        if (m_owner(tt) == side + 1) begin
          eb = br ? m_beats(msz) : 1;
          edone = ls;
        end else eb = m_beats(msz);
      end
    end
    if (side == 0) got = {src_go, src_ack, src_blk_done, src_go_burst, 23'd0, src_go_beats};
    else           got = {dst_go, dst_ack, dst_blk_done, dst_go_burst, 23'd0, dst_go_beats};
    exp = {1'(ego), 1'(eack), 1'(edone), 1'(ego != 0 && eb > 1), 23'd0, 5'(eb)};
    if (side == 0 && ego != 0) got[4:0] = src_go_beats;
    if (side == 1 && ego != 0) got[4:0] = dst_go_beats;
    if (ego == 0) begin got[28:0] = '0; exp[28:0] = '0; end
    // R4 R5 R6 R7 R9 R3 R10: start/ack/done/burst/beats for this stimulus
    check($sformatf("R4/R5/R6/R7/R9 side=%0d tt=%0d msz=%0d req=%b%b%b en=%0d", side, tt, msz, sr, br, ls, en), got, exp);
    check("R10 other side quiet", side == 0 ? dst_go : src_go, 0);
    idle_all();
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++; n_errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11: reset state
    check("R11 reset outputs", {src_go, src_ack, src_go_burst, src_go_beats, src_blk_done,
                                dst_go, dst_ack, dst_go_burst, dst_go_beats, dst_blk_done}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 R2: decode of all eight codes
    for (int tt = 0; tt < 8; tt++) begin
      xfer_type = 3'(tt);
      #1;
      check($sformatf("R1 src kind tt=%0d", tt), src_is_periph, m_periph(0, tt));
      check($sformatf("R1 dst kind tt=%0d", tt), dst_is_periph, m_periph(1, tt));
      check($sformatf("R2 owner tt=%0d", tt), flow_owner, m_owner(tt));
      check($sformatf("R2 count mode tt=%0d", tt), count_ends_block, m_owner(tt) == 0);
    end

    // R3: cfg_err for every burst code
    for (int m = 0; m < 8; m++) begin
      src_msize = 3'(m); dst_msize = '0; #1;
      check($sformatf("R3 cfg_err src code %0d", m), cfg_err, m >= 4);
      src_msize = '0; dst_msize = 3'(m); #1;
      check($sformatf("R3 cfg_err dst code %0d", m), cfg_err, m >= 4);
    end

    // Full sweep: codes x burst codes x sides x request patterns
    for (int tt = 0; tt < 8; tt++)
      for (int m = 0; m < 8; m++)
        for (int s = 0; s < 2; s++)
          for (int r = 0; r < 8; r++)
            run_txn(s, tt, m, r[0], r[1], r[2], 1'b1);

    // R10: disabled channel never starts
    for (int tt = 0; tt < 8; tt++)
      for (int s = 0; s < 2; s++)
        run_txn(s, tt, 2, 1'b1, 1'b1, 1'b1, 1'b0);

    // R3: one illegal side blocks the other legal side
    @(negedge clk);
    chan_en = 1; xfer_type = 3'b000; src_msize = 3'd1; dst_msize = 3'd5;
    set_side(0, 1, 0, 0, 0);
    @(negedge clk);
    check("R3 legal side blocked by other side error", src_go, 0);
    idle_all(); dst_msize = 3'd0;
    @(negedge clk);

    // R10: memory side with ready held starts every other cycle
    xfer_type = 3'b000; src_msize = 3'd2;
    set_side(0, 1, 0, 0, 0);
    @(negedge clk); check("R10 mem first start", src_go, 1);
    check("R4 mem beats", src_go_beats, 8);
    @(negedge clk); check("R10 no back-to-back", src_go, 0);
    @(negedge clk); check("R10 mem next start", src_go, 1);
    idle_all();
    @(negedge clk);

    // R8: held request is not re-serviced until dropped
    xfer_type = 3'b010; src_msize = 3'd1;
    set_side(0, 1, 1, 0, 0);
    @(negedge clk); check("R8 first service", src_go, 1);
    check("R7 ack with service", src_ack, 1);
    @(negedge clk); check("R8 held request ignored", src_go, 0);
    check("R7 ack lasts one cycle", src_ack, 0);
    @(negedge clk); check("R8 held request still ignored", src_go, 0);
    set_side(0, 1, 0, 0, 0);
    @(negedge clk); check("R8 no start while dropped", src_go, 0);
    set_side(0, 1, 0, 1, 0);
    @(negedge clk); check("R8 served after drop", src_go, 1);
    check("R8 beats after drop", src_go_beats, 4);
    idle_all();
    @(negedge clk);

    // R9: last from non-owner destination ignored in source-owned mode
    xfer_type = 3'b101; dst_msize = 3'd0;
    set_side(1, 1, 1, 0, 1);
    @(negedge clk); check("R9 non-owner last ignored", dst_blk_done, 0);
    check("R5 non-owner serviced", dst_go, 1);
    idle_all();
    repeat (2) @(negedge clk);

    finish_run();
  end
endmodule